// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data buses, called A and B, through a pair of storage registers, one for each direction. The A-to-B register samples the A bus on the rising edge of its own capture clock. The B-to-A register samples the B bus on the rising edge of a second, independent capture clock. Each outgoing side chooses, through its own select input, between two sources. One is the live value arriving from the opposite bus. The other is the value held in that direction's register. Held data can therefore be replayed later, and traffic can be stored while both buses are isolated.

An active-low output enable and a direction input pick the operating mode, which is decoded combinationally with no state register. MODE_ISOLATE applies while the enable is high, and neither bus is driven. MODE_DRIVE_B applies while the enable is low and direction is high: the B bus is driven and A is an input. MODE_DRIVE_A applies while the enable is low and direction is low: the A bus is driven and B is an input. The mode follows the two control inputs directly, with no sequencing between modes.

Each bus is modelled as three separate signals: a data input, a data output and an output-enable flag. A pad wrapper above this block can merge the three into a tri-state pin. Data width is a parameter, and every bit lane behaves the same way.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers hold zero, and rising edges on `clk_ab` or `clk_ba` do not change them. With `sel_ab` = 1 and `sel_ba` = 1, this makes `b_out` and `a_out` read zero.
- R2: On each rising edge of `clk_ab`, the A-to-B register loads `a_in`. On each rising edge of `clk_ba`, the B-to-A register loads `b_in`. Between edges, each register keeps its value whatever its data input does.
- R3: Capture into either register happens on every edge of its clock, whatever the values of `oe_n` and `dir`, including isolation and the case where the captured bus is the one being driven.
- R4: With `oe_n` = 1, `a_oe` = 0 and `b_oe` = 0.
- R5: With `oe_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0. With `oe_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0.
- R6: `a_oe` and `b_oe` are never both 1.
- R7: With `sel_ab` = 0, `b_out` equals `a_in` in the same cycle, with no register in the path. With `sel_ab` = 1, `b_out` equals the A-to-B register, which changes only after a `clk_ab` edge. The path from B to A follows the same rule, using `sel_ba`, `b_in` and the B-to-A register, to produce `a_out`.
- R8: `a_out` and `b_out` carry the selected path value for every setting of `oe_n` and `dir`. Only `a_oe` and `b_oe` depend on those two inputs.
- R9: Rising edges on `clk_ab` and `clk_ba` at the same instant load both registers, each from its own bus, without interference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset that clears both registers |
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1 drives the B bus, 0 drives the A bus |
| sel_ab | input | 1 | Source toward B: 0 live A data, 1 stored A data |
| sel_ba | input | 1 | Source toward A: 0 live B data, 1 stored B data |
| a_in | input | W | Value currently present on the A bus |
| a_out | output | W | Value offered to the A bus |
| a_oe | output | 1 | A bus driver enable |
| b_in | input | W | Value currently present on the B bus |
| b_out | output | W | Value offered to the B bus |
| b_oe | output | 1 | B bus driver enable |

## Verification
All sixteen combinations of `oe_n`, `dir`, `sel_ab` and `sel_ba` are applied while the live bus values differ from both stored values. A wrong source or a wrong driver flag therefore shows up as a distinct output value. Capture is exercised under isolation, under both driving directions and with both clocks firing together. The two registers are loaded with different patterns, so a swapped clock or a swapped data input is visible. Bus values are changed between edges while the stored source is selected, which separates a true register from a transparent path. Clock edges applied during reset confirm that reset takes priority over capture.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    // Driving mode chosen by the output enable and direction inputs
    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'b00,
        MODE_DRIVE_B = 2'b01,
        MODE_DRIVE_A = 2'b10
    } xcvr_mode_e;

endpackage

// File: rtl/xcvr_mode_dec.sv
`timescale 1ns/1ps
module xcvr_mode_dec
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);

    xcvr_mode_e mode;

    // Mode selection: the enable dominates, the direction picks the driven side
    always_comb begin
        mode = MODE_ISOLATE;
        if (!oe_n) begin
            mode = dir ? MODE_DRIVE_B : MODE_DRIVE_A;
        end
    end

    // Driver flags: at most one is set in any mode
    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (mode)
            MODE_ISOLATE: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
            MODE_DRIVE_B: b_oe = 1'b1;
            MODE_DRIVE_A: a_oe = 1'b1;
            default: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Sample the bus on every rising edge; no enable gates the capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_path_sel.sv
`timescale 1ns/1ps
module xcvr_path_sel #(
    parameter int W = 8
) (
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    // One identical two-way selector per bit lane
    for (genvar lane = 0; lane < W; lane++) begin : g_lane
        assign y[lane] = use_stored ? stored[lane] : live[lane];
    end

endmodule

// File: rtl/reg_bus_xcvr.sv
`timescale 1ns/1ps
module reg_bus_xcvr #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] held_ab;
    logic [W-1:0] held_ba;

    // Storage toward B, loaded from the A bus
    xcvr_store_reg #(.W(W)) u_store_ab (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (held_ab)
    );

    // Storage toward A, loaded from the B bus
    xcvr_store_reg #(.W(W)) u_store_ba (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (held_ba)
    );

    xcvr_path_sel #(.W(W)) u_sel_to_b (
        .use_stored (sel_ab),
        .live       (a_in),
        .stored     (held_ab),
        .y          (b_out)
    );

    xcvr_path_sel #(.W(W)) u_sel_to_a (
        .use_stored (sel_ba),
        .live       (b_in),
        .stored     (held_ba),
        .y          (a_out)
    );

    xcvr_mode_dec u_mode (
        .oe_n (oe_n),
        .dir  (dir),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );

endmodule

// File: rtl/xcvr_chk.sv
`timescale 1ns/1ps
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    // Set once a capture edge has been seen out of reset
    logic ab_primed;
    logic ba_primed;

    always_ff @(posedge clk_ab or negedge rst_n) begin
        if (!rst_n) ab_primed <= 1'b0;
        else        ab_primed <= 1'b1;
    end

    always_ff @(posedge clk_ba or negedge rst_n) begin
        if (!rst_n) ba_primed <= 1'b0;
        else        ba_primed <= 1'b1;
    end

    always_comb begin
        if (rst_n) begin
            AST_ONE_DRIVER: assert (!(a_oe && b_oe)) else $error("both buses driven"); // R6
            AST_ISOLATE_QUIET: assert (!oe_n || (!a_oe && !b_oe)) else $error("driver on while isolated"); // R4
            AST_DIR_TO_B: assert (oe_n || !dir || b_oe) else $error("B not driven"); // R5
            AST_DIR_TO_A: assert (oe_n || dir || a_oe) else $error("A not driven"); // R5
        end
    end

    AST_LIVE_TO_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !sel_ab |-> (b_out == a_in)) else $error("live path to B wrong"); // R7

    AST_LIVE_TO_A: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !sel_ba |-> (a_out == b_in)) else $error("live path to A wrong"); // R7

    AST_STORED_TO_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (ab_primed && sel_ab) |-> (b_out == $past(a_in))) else $error("stored A value wrong"); // R2

    AST_STORED_TO_A: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (ba_primed && sel_ba) |-> (a_out == $past(b_in))) else $error("stored B value wrong"); // R2

endmodule

bind reg_bus_xcvr xcvr_chk #(.W(W)) u_chk (
    .rst_n  (rst_n),
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/reg_bus_xcvr_tb.sv
`timescale 1ns/1ps
module reg_bus_xcvr_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         oe_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    // Bench-side record of what each register must hold
    logic [W-1:0] exp_ab = '0;
    logic [W-1:0] exp_ba = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    reg_bus_xcvr #(.W(W)) u_dut (
        .rst_n  (rst_n),
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_in   (b_in),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL R1..R9 watchdog: actual=%0d cycles expected<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Rising edge on one or both capture clocks, then settle
    task automatic pulse(input logic do_ab, input logic do_ba);
        #1;
        if (rst_n) begin
            if (do_ab) exp_ab = a_in;
            if (do_ba) exp_ba = b_in;
        end
        clk_ab = do_ab;
        clk_ba = do_ba;
        #2;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        oe_n = 1'b1;
        sel_ab = 1'b1;
        sel_ba = 1'b1;
        a_in = 8'hFF;
        b_in = 8'hEE;
        pulse(1'b1, 1'b1);
        chk("R1 b_out in reset", b_out, '0);
        chk("R1 a_out in reset", a_out, '0);
        #3 rst_n = 1'b1;
        #2;
        chk("R1 b_out after reset", b_out, '0);
        chk("R1 a_out after reset", a_out, '0);
    endtask

    task automatic t_isolated_capture();
        oe_n = 1'b1;
        dir = 1'b1;
        sel_ab = 1'b1;
        sel_ba = 1'b1;
        a_in = 8'h5A;
        pulse(1'b1, 1'b0);
        b_in = 8'hC3;
        pulse(1'b0, 1'b1);
        chk("R4 a_oe isolated", {7'd0, a_oe}, 8'd0);
        chk("R4 b_oe isolated", {7'd0, b_oe}, 8'd0);
        chk("R3 stored A while isolated", b_out, 8'h5A);
        chk("R3 stored B while isolated", a_out, 8'hC3);
    endtask

    task automatic t_hold();
        a_in = 8'h00;
        b_in = 8'hFF;
        #3;
        chk("R2 A register holds", b_out, 8'h5A);
        chk("R2 B register holds", a_out, 8'hC3);
        a_in = 8'h81;
        pulse(1'b1, 1'b0);
        chk("R2 A register loads on clk_ab", b_out, 8'h81);
        chk("R2 B register untouched by clk_ab", a_out, 8'hC3);
    endtask

    task automatic t_live();
        sel_ab = 1'b0;
        sel_ba = 1'b0;
        for (int k = 0; k < 4; k++) begin
            a_in = 8'h11 << k;
            b_in = ~(8'h3 << k);
            #1;
            chk("R7 live A to B", b_out, a_in);
            chk("R7 live B to A", a_out, b_in);
        end
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 16; m++) begin
            oe_n = m[3];
            dir = m[2];
            sel_ab = m[1];
            sel_ba = m[0];
            a_in = 8'h20 + 8'(m);
            b_in = 8'hB0 + 8'(m);
            #1;
            chk("R5 a_oe from control", {7'd0, a_oe}, {7'd0, !oe_n && !dir});
            chk("R5 b_oe from control", {7'd0, b_oe}, {7'd0, !oe_n && dir});
            chk("R6 single driver", {7'd0, a_oe && b_oe}, 8'd0);
            chk("R8 b_out path value", b_out, sel_ab ? exp_ab : a_in);
            chk("R8 a_out path value", a_out, sel_ba ? exp_ba : b_in);
        end
    endtask

    task automatic t_capture_driving();
        sel_ab = 1'b1;
        sel_ba = 1'b1;
        oe_n = 1'b0;
        dir = 1'b1;
        a_in = 8'h11;
        b_in = 8'h22;
        pulse(1'b1, 1'b1);
        chk("R3 capture A while B driven", b_out, 8'h11);
        chk("R3 capture B while B driven", a_out, 8'h22);
        dir = 1'b0;
        a_in = 8'h33;
        b_in = 8'h44;
        pulse(1'b1, 1'b1);
        chk("R3 capture A while A driven", b_out, 8'h33);
        chk("R3 capture B while A driven", a_out, 8'h44);
    endtask

    task automatic t_simultaneous();
        a_in = 8'hA5;
        b_in = 8'h5A;
        pulse(1'b1, 1'b1);
        chk("R9 simultaneous A capture", b_out, 8'hA5);
        chk("R9 simultaneous B capture", a_out, 8'h5A);
    endtask

    task automatic t_stored_latency();
        sel_ab = 1'b1;
        a_in = 8'h77;
        #1;
        chk("R7 stored path waits for edge", b_out, 8'hA5);
        pulse(1'b1, 1'b0);
        chk("R7 stored path after edge", b_out, 8'h77);
        sel_ab = 1'b0;
        #1;
        chk("R7 back to live", b_out, 8'h77);
        a_in = 8'h0F;
        #1;
        chk("R7 live follows input", b_out, 8'h0F);
    endtask

    initial begin
        t_reset();
        t_isolated_capture();
        t_hold();
        t_live();
        t_sweep();
        t_capture_driving();
        t_simultaneous();
        t_stored_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule